// File: doc/BRIEF.md
# VBI Caption Line Selector

This block picks the video lines inside the vertical blanking interval that a closed-caption data slicer should work on. It watches separated horizontal and vertical sync pulses, counts horizontal sync pulses from the start of each field, and raises a slice-enable strobe for the line whose index matches a programmed value. There are two such line selectors, main and sub. They share one line counter, and each one has its own field qualifier, so each can act in field 1 only, in field 2 only, or in both fields.

A third strobe marks the line whose clock run-in the slicer integrates to build its reference level. A select bit chooses whether this reference line follows the main selector or the sub selector, together with that selector's field rule. The block also works out the field parity when vertical sync falls and holds it as a readable flag.

Both sync inputs may be asynchronous to the system clock. Every strobe lasts exactly one line, from one horizontal sync edge to the next. Analog slicing and bit recovery belong to other blocks.

Top module: `vbi_line_select`

## Requirements
- R1: Each rising edge of `hsep_in` advances the line counter once, however many clocks the pulse stays high.
- R2: A falling edge of `vsep_in` clears the line counter and drops all three strobes. The k-th `hsep_in` rise after that has line index k, so a programmed line value of 0 never matches.
- R3: `main_slice_en` goes high three clocks after the `hsep_in` rise whose index equals `main_line`, provided the main field rule passes. It stays high until the next `hsep_in` rise is registered.
- R4: `sub_slice_en` follows the same rule as R3, using `sub_line` and `sub_fld`.
- R5: Field control encoding: when bit 1 is 1, lines match in both fields. When bit 1 is 0, bit 0 = 1 allows field 1 only and bit 0 = 0 allows field 2 only.
- R6: `field_is_f1` becomes 1 when `vsep_in` falls less than `HALF_LINE_CLKS` clocks after the last `hsep_in` rise, and 0 otherwise. It changes at no other time.
- R7: `ref_line_en` applies the rule of R3 with `main_line`/`main_fld` when `ref_sel` = 0, and with `sub_line`/`sub_fld` when `ref_sel` = 1.
- R8: The line counter stops at 32, one past the largest line number. A line value of 31 therefore matches exactly once per field, however many lines follow.
- R9: Line numbers, field controls and `ref_sel` are sampled only at `hsep_in` rises. A change during a line leaves every strobe as it is until the next rise.
- R10: After synchronous reset all strobes are 0, `field_is_f1` is 0 and the line counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsep_in | input | 1 | Separated horizontal sync, asynchronous |
| vsep_in | input | 1 | Separated vertical sync, asynchronous |
| main_line | input | 5 | Main selector line index |
| main_fld | input | 2 | Main selector field control |
| sub_line | input | 5 | Sub selector line index |
| sub_fld | input | 2 | Sub selector field control |
| ref_sel | input | 1 | Reference line source: 0 main, 1 sub |
| main_slice_en | output | 1 | Main line slice strobe |
| sub_slice_en | output | 1 | Sub line slice strobe |
| ref_line_en | output | 1 | Reference-level line strobe |
| field_is_f1 | output | 1 | Field flag, 1 = field 1 |

## Verification
A line counter that is off by one or that double counts shows at the ports as a strobe on the wrong line. The error appears three clocks after the offending horizontal sync edge, so the bench compares every strobe against a model line index after every pulse, including wide ones. A wrong parity decision shows on `field_is_f1` within three clocks of the vertical sync fall, and it then suppresses or enables the gated strobes for the whole field. For that reason both field outcomes are checked, each with all four field-control encodings. A counter that wraps instead of saturating shows as a second strobe for line 31 late in the field.

// File: rtl/vbi_sel_pkg.sv
`timescale 1ns/1ps
package vbi_sel_pkg;

    localparam int LINE_W = 5;
    localparam int CNT_W  = LINE_W + 1;
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(1 << LINE_W);

    typedef enum logic {
        FIELD_2 = 1'b0,
        FIELD_1 = 1'b1
    } field_e;

    typedef struct packed {
        logic both;
        logic pick_f1;
    } fld_ctl_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        fld_ctl_t          fld;
    } line_cfg_t;

    function automatic logic field_pass(input fld_ctl_t c, input field_e f);
        return c.both || (c.pick_f1 == (f == FIELD_1));
    endfunction

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
        return (c == CNT_SAT) ? CNT_SAT : c + CNT_W'(1);
    endfunction

    function automatic logic line_hit(input logic [CNT_W-1:0] c, input logic [LINE_W-1:0] l);
        return (c[CNT_W-1] == 1'b0) && (c[LINE_W-1:0] == l);
    endfunction

endpackage

// File: rtl/vbi_edge_sync.sv
`timescale 1ns/1ps
module vbi_edge_sync #(
    parameter int STAGES = 2,
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_pulse = sync_q[STAGES-1] & ~last_q;
        end else begin : g_fall
            assign edge_pulse = ~sync_q[STAGES-1] & last_q;
        end
    endgenerate

    assert_single_R1: assert property (@(posedge clk) disable iff (rst)
        edge_pulse |=> !edge_pulse);
endmodule

// File: rtl/vbi_line_count.sv
`timescale 1ns/1ps
module vbi_line_count
    import vbi_sel_pkg::*;
#(
    parameter int HALF_LINE_CLKS = 64,
    localparam int HC_W = $clog2(HALF_LINE_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_rise,
    input  logic             v_fall,
    output logic [CNT_W-1:0] cnt_next,
    output field_e           field
);
    logic [CNT_W-1:0] cnt_q;
    logic [HC_W-1:0]  hclk_q;
    field_e           field_q;

    assign cnt_next = count_step(cnt_q);
    assign field    = field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (v_fall) begin
            cnt_q <= '0;
        end else if (h_rise) begin
            cnt_q <= cnt_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hclk_q <= '0;
        end else if (h_rise) begin
            hclk_q <= '0;
        end else if (hclk_q != HC_W'(HALF_LINE_CLKS)) begin
            hclk_q <= hclk_q + HC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= FIELD_2;
        end else if (v_fall) begin
            field_q <= (hclk_q < HC_W'(HALF_LINE_CLKS)) ? FIELD_1 : FIELD_2;
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        v_fall |=> cnt_q == '0);
    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (h_rise && !v_fall && cnt_q != CNT_SAT) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!h_rise && !v_fall) |=> $stable(cnt_q));
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_SAT);
    assert_field_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !v_fall |=> $stable(field_q));
endmodule

// File: rtl/vbi_line_match.sv
`timescale 1ns/1ps
module vbi_line_match
    import vbi_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             h_rise,
    input  logic             v_fall,
    input  logic [CNT_W-1:0] cnt_next,
    input  line_cfg_t        cfg,
    input  field_e           field,
    output logic             strobe
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else if (v_fall) begin
            strobe_q <= 1'b0;
        end else if (h_rise) begin
            strobe_q <= line_hit(cnt_next, cfg.line) && field_pass(cfg.fld, field);
        end
    end

    assign strobe = strobe_q;

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!h_rise && !v_fall) |=> $stable(strobe_q));
    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (h_rise && !field_pass(cfg.fld, field)) |=> !strobe_q);
    assert_vclr_R2: assert property (@(posedge clk) disable iff (rst)
        v_fall |=> !strobe_q);
endmodule

// File: rtl/vbi_line_select.sv
`timescale 1ns/1ps
module vbi_line_select
    import vbi_sel_pkg::*;
#(
    parameter int HALF_LINE_CLKS = 64,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsep_in,
    input  logic              vsep_in,
    input  logic [LINE_W-1:0] main_line,
    input  logic [1:0]        main_fld,
    input  logic [LINE_W-1:0] sub_line,
    input  logic [1:0]        sub_fld,
    input  logic              ref_sel,
    output logic              main_slice_en,
    output logic              sub_slice_en,
    output logic              ref_line_en,
    output logic              field_is_f1
);
    localparam int N_SEL = 3;

    logic             h_rise, v_fall;
    logic [CNT_W-1:0] cnt_next;
    field_e           field;
    line_cfg_t        cfg_main, cfg_sub;
    line_cfg_t        cfgs [N_SEL];
    logic [N_SEL-1:0] strobes;

    vbi_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_hsync (
        .clk(clk), .rst(rst), .din(hsep_in), .edge_pulse(h_rise));
    vbi_edge_sync #(.STAGES(SYNC_STAGES), .RISING(1'b0)) u_vsync (
        .clk(clk), .rst(rst), .din(vsep_in), .edge_pulse(v_fall));

    vbi_line_count #(.HALF_LINE_CLKS(HALF_LINE_CLKS)) u_count (
        .clk(clk), .rst(rst), .h_rise(h_rise), .v_fall(v_fall),
        .cnt_next(cnt_next), .field(field));

    assign cfg_main = '{line: main_line, fld: fld_ctl_t'(main_fld)};
    assign cfg_sub  = '{line: sub_line,  fld: fld_ctl_t'(sub_fld)};
    assign cfgs[0]  = cfg_main;
    assign cfgs[1]  = cfg_sub;
    assign cfgs[2]  = ref_sel ? cfg_sub : cfg_main;

    generate
        for (genvar i = 0; i < N_SEL; i++) begin : g_sel
            vbi_line_match u_match (
                .clk(clk), .rst(rst), .h_rise(h_rise), .v_fall(v_fall),
                .cnt_next(cnt_next), .cfg(cfgs[i]), .field(field),
                .strobe(strobes[i]));
        end
    endgenerate

    assign main_slice_en = strobes[0];
    assign sub_slice_en  = strobes[1];
    assign ref_line_en   = strobes[2];
    assign field_is_f1   = (field == FIELD_1);

    assert_ref_src_R7: assert property (@(posedge clk) disable iff (rst)
        ref_line_en |-> (main_slice_en || sub_slice_en));
endmodule

// File: tb/vbi_line_select_tb.sv
`timescale 1ns/1ps
module vbi_line_select_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsep_in = 1'b0, vsep_in = 1'b0;
    logic [4:0] main_line = '0, sub_line = '0;
    logic [1:0] main_fld = '0, sub_fld = '0;
    logic ref_sel = 1'b0;
    logic main_slice_en, sub_slice_en, ref_line_en, field_is_f1;

    int checks = 0, fails = 0;
    int mcnt = 0;
    bit mf1 = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vbi_line_select u_dut (
        .clk(clk), .rst(rst), .hsep_in(hsep_in), .vsep_in(vsep_in),
        .main_line(main_line), .main_fld(main_fld),
        .sub_line(sub_line), .sub_fld(sub_fld), .ref_sel(ref_sel),
        .main_slice_en(main_slice_en), .sub_slice_en(sub_slice_en),
        .ref_line_en(ref_line_en), .field_is_f1(field_is_f1));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (line %0d)", req, act, exp, mcnt);
        end
    endtask

    function automatic bit fok(input logic [1:0] c, input bit f1);
        return c[1] || (c[0] == f1);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Start a field: Vsep falls d clocks after an Hsep rise (R6)
    task automatic start_field(input bit f1);
        vsep_in = 1'b1;
        tick(6);
        hsep_in = 1'b1; tick(4); hsep_in = 1'b0;
        tick(f1 ? 6 : 96);
        vsep_in = 1'b0;
        tick(8);
        mcnt = 0; mf1 = f1;
        chk("R6 field flag", field_is_f1, f1);
        chk("R2 cleared main", main_slice_en, 1'b0);
        chk("R2 cleared sub", sub_slice_en, 1'b0);
    endtask

    // One line: Hsep pulse then compare strobes with model (R3 R4 R5 R7)
    task automatic do_line(input int width);
        hsep_in = 1'b1; tick(width); hsep_in = 1'b0;
        tick(5);
        if (mcnt < 32) mcnt++;
        chk("R3 main", main_slice_en, (mcnt == main_line) && fok(main_fld, mf1));
        chk("R4 sub", sub_slice_en, (mcnt == sub_line) && fok(sub_fld, mf1));
        chk("R7 ref", ref_line_en, ref_sel ? ((mcnt == sub_line) && fok(sub_fld, mf1))
                                           : ((mcnt == main_line) && fok(main_fld, mf1)));
        tick(10);
    endtask

    task automatic t_reset;
        chk("R10 main", main_slice_en, 1'b0);
        chk("R10 sub", sub_slice_en, 1'b0);
        chk("R10 ref", ref_line_en, 1'b0);
        chk("R10 field", field_is_f1, 1'b0);
    endtask

    task automatic t_field1_main;
        main_line = 5'd17; main_fld = 2'b01; sub_line = 5'd5; sub_fld = 2'b00; ref_sel = 1'b0;
        start_field(1'b1);
        for (int i = 0; i < 20; i++) do_line(3);
    endtask

    task automatic t_field2_sub;
        main_line = 5'd9; main_fld = 2'b01; sub_line = 5'd5; sub_fld = 2'b00; ref_sel = 1'b1;
        start_field(1'b0);
        for (int i = 0; i < 12; i++) do_line(3);
    endtask

    task automatic t_both_fields;
        main_line = 5'd3; main_fld = 2'b10; sub_line = 5'd4; sub_fld = 2'b11; ref_sel = 1'b1;
        start_field(1'b0);
        for (int i = 0; i < 6; i++) do_line(3);
        start_field(1'b1);
        for (int i = 0; i < 6; i++) do_line(3);
    endtask

    task automatic t_wide_and_zero;
        main_line = 5'd0; main_fld = 2'b10; sub_line = 5'd6; sub_fld = 2'b10; ref_sel = 1'b0;
        start_field(1'b1);
        for (int i = 0; i < 8; i++) do_line(14); // R1 wide pulses counted once, R2 line 0 idle
    endtask

    task automatic t_saturate;
        main_line = 5'd31; main_fld = 2'b10; sub_line = 5'd30; sub_fld = 2'b10; ref_sel = 1'b0;
        start_field(1'b0);
        for (int i = 0; i < 40; i++) do_line(2); // R8 no second hit past line 31
    endtask

    task automatic t_mid_change;
        main_line = 5'd3; main_fld = 2'b10; sub_line = 5'd20; sub_fld = 2'b10; ref_sel = 1'b0;
        start_field(1'b1);
        for (int i = 0; i < 3; i++) do_line(3);
        main_line = 5'd7; main_fld = 2'b00; ref_sel = 1'b1;
        tick(3);
        chk("R9 main held", main_slice_en, 1'b1);
        chk("R9 ref held", ref_line_en, 1'b1);
        chk("R6 flag steady", field_is_f1, 1'b1);
        main_fld = 2'b10;
        for (int i = 0; i < 5; i++) do_line(3);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_field1_main();
        t_field2_sub();
        t_both_fields();
        t_wide_and_zero();
        t_saturate();
        t_mid_change();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule